// File: doc/BRIEF.md
# Multiplexed Parallel I/O Controller

This block sits between a row of chip pads and the on-chip peripherals that share them. Each pin is owned either by the controller or by its peripheral. While the controller owns a pin, software chooses its direction and output level through a small register bus. While the peripheral owns it, the peripheral's output and output enable go straight to the pad. Some pins are not shared with any peripheral. Those pins always belong to the controller.

Every register that changes pin state has a write-one-to-set word and a write-one-to-clear word, so software never needs a read-modify-write. The pad inputs pass through a two-flop synchronizer and an optional per-pin glitch filter. A change detector then sets a sticky pending bit per pin, and reading the pending word clears it. An interrupt output reports any pending pin whose interrupt enable is set.

Word addresses: 0 owner-set, 1 owner-clear, 2 owner-status, 3 direction-set, 4 direction-clear, 5 direction-status, 6 data-set, 7 data-clear, 8 data-status, 9 filter-set, 10 filter-clear, 11 filter-status, 12 irq-enable-set, 13 irq-enable-clear, 14 irq-enable-status, 15 pad-level, 16 change-pending.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset every pin reads as controller-owned (status word 2 all ones). Direction (word 5), data (8), filter (11), irq-enable (14) and pending (16) all read 0. pad_oe is 0 and irq is 0.
- R2: Writing ones to word 1 hands the selected shared pins to their peripheral. Writing ones to word 0 takes them back. In word 2, bit=1 means controller-owned and bit=0 means peripheral-owned.
- R3: Dedicated pins (bits clear in parameter SHARED, by default pins 6 and 7) ignore writes to words 0 and 1, and their bits in word 2 always read 1.
- R4: per_in reads 0 on controller-owned pins and follows pad_in on peripheral-owned pins.
- R5: Words 3 and 4 set and clear the direction bits, and word 5 reads them back. On controller-owned pins, pad_oe equals the direction bit.
- R6: Words 6 and 7 set and clear the data bits, and word 8 reads them back. On controller-owned pins, pad_out equals the data bit.
- R7: On peripheral-owned pins, pad_out follows per_out and pad_oe follows per_oe.
- R8: Word 15 returns the pad level after the two-flop synchronizer, whoever owns the pin.
- R9: Words 9 and 10 set and clear the filter enables, and word 11 reads them back. A filtered pin drops a pulse one sample long. The pending bit of a filtered pin is set 5 clock edges after a lasting pad change. The pending bit of an unfiltered pin is set after 4 edges.
- R10: Every change of the conditioned input sets that pin's bit in word 16. Reading word 16 returns the bits and clears them.
- R11: Words 12 and 13 set and clear the interrupt enables, and word 14 reads them back. irq is high exactly when some pending bit has its enable set.
- R12: Writes take effect at the clock edge that samples bus_wr. Read data appears on bus_rdata after the edge that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Registered read data |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| per_out | input | NPINS | Peripheral output values |
| per_oe | input | NPINS | Peripheral output enables |
| per_in | output | NPINS | Input returned to peripherals |
| irq | output | 1 | Input-change interrupt |

## Verification
The mux paths (pad_out, pad_oe, per_in) are combinational, so the bench checks them one half-cycle after the write edge that changed ownership, direction or data.

Read data has a latency of one edge. The driver pushes each expected word into a queue as it issues the read. The monitor pops and compares at the falling edge after the sampling edge.

For input changes, the bench counts rising edges from the falling edge where pad_in moves. For an unfiltered pin, it checks that irq is still low after 3 edges and high after 4. For a filtered pin, it checks low after 4 edges and high after 5. Pulses one sample long are then read back as absent (filtered pin) or present (unfiltered pin).

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl #(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] SHARED = 8'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [4:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] per_out,
  input  logic [NPINS-1:0] per_oe,
  output logic [NPINS-1:0] per_in,
  output logic             irq
);
  localparam logic [4:0] A_OWN_S = 5'd0,  A_OWN_C = 5'd1,  A_OWN_R = 5'd2;
  localparam logic [4:0] A_DIR_S = 5'd3,  A_DIR_C = 5'd4,  A_DIR_R = 5'd5;
  localparam logic [4:0] A_DAT_S = 5'd6,  A_DAT_C = 5'd7,  A_DAT_R = 5'd8;
  localparam logic [4:0] A_FLT_S = 5'd9,  A_FLT_C = 5'd10, A_FLT_R = 5'd11;
  localparam logic [4:0] A_IEN_S = 5'd12, A_IEN_C = 5'd13, A_IEN_R = 5'd14;
  localparam logic [4:0] A_PAD_R = 5'd15, A_PND_R = 5'd16;

  logic [NPINS-1:0] own_q, dir_q, dat_q, flt_q, ien_q;
  logic [NPINS-1:0] s1, s2, s3, filt, prev, pend;
  logic [NPINS-1:0] own_st, chg, wmask;
  logic             rd_pend;

  assign own_st  = own_q | ~SHARED;
  assign wmask   = bus_wr ? bus_wdata : '0;
  assign chg     = filt ^ prev;
  assign rd_pend = bus_rd && bus_addr == A_PND_R;

  assign pad_out = (own_st & dat_q) | (~own_st & per_out);
  assign pad_oe  = (own_st & dir_q) | (~own_st & per_oe);
  assign per_in  = ~own_st & pad_in;
  assign irq     = |(pend & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= SHARED;
      dir_q <= '0;
      dat_q <= '0;
      flt_q <= '0;
      ien_q <= '0;
    end else begin
      if (bus_addr == A_OWN_S) own_q <= (own_q | wmask) & SHARED;
      if (bus_addr == A_OWN_C) own_q <= own_q & ~(wmask & SHARED);
      if (bus_addr == A_DIR_S) dir_q <= dir_q | wmask;
      if (bus_addr == A_DIR_C) dir_q <= dir_q & ~wmask;
      if (bus_addr == A_DAT_S) dat_q <= dat_q | wmask;
      if (bus_addr == A_DAT_C) dat_q <= dat_q & ~wmask;
      if (bus_addr == A_FLT_S) flt_q <= flt_q | wmask;
      if (bus_addr == A_FLT_C) flt_q <= flt_q & ~wmask;
      if (bus_addr == A_IEN_S) ien_q <= ien_q | wmask;
      if (bus_addr == A_IEN_C) ien_q <= ien_q & ~wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; filt <= '0; prev <= '0; pend <= '0;
    end else begin
      s1   <= pad_in;
      s2   <= s1;
      s3   <= s2;
      filt <= (flt_q & ((s2 ~^ s3) & s2 | ~(s2 ~^ s3) & filt)) | (~flt_q & s2);
      prev <= filt;
      pend <= (rd_pend ? '0 : pend) | chg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_OWN_R: bus_rdata <= own_st;
        A_DIR_R: bus_rdata <= dir_q;
        A_DAT_R: bus_rdata <= dat_q;
        A_FLT_R: bus_rdata <= flt_q;
        A_IEN_R: bus_rdata <= ien_q;
        A_PAD_R: bus_rdata <= s2;
        A_PND_R: bus_rdata <= pend;
        default: bus_rdata <= '0;
      endcase
    end
  end

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OWN_C) |=> ((own_st & $past(bus_wdata) & SHARED) == '0));
  a_r3_dedicated: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_OWN_C || bus_addr == A_OWN_S)) |=> ((~SHARED & ~own_st) == '0));
  a_r4_per_in_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (per_in & own_st) == '0);
  a_r5_dir_applies: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & own_st) == '0);
  a_r7_periph_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ per_out) & ~own_st) == '0);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> pend == $past(chg));
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & ien_q) != '0));
endmodule

// File: tb/tb_gpio_mux_ctrl.sv
module tb_gpio_mux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  logic [N-1:0] per_out = '0, per_oe = '0, per_in;
  logic irq;
  int checks = 0, errors = 0;
  logic rd_seen = 0;
  logic [N-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_ctrl #(.NPINS(N), .SHARED(8'h3F)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq));

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) if (rd_seen) begin
    if (exp_q.size() == 0) chk("R12 unexpected read", bus_rdata, bus_rdata ^ 1);
    else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(logic [4:0] a, logic [N-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [N-1:0] exp, string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(2); rst_n = 1; edges(1);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(5'd2, 8'hFF, "R1 owner");
    rd(5'd5, 8'h00, "R1 dir");
    rd(5'd8, 8'h00, "R1 data");
    rd(5'd11, 8'h00, "R1 filter");
    rd(5'd14, 8'h00, "R1 ien");
    rd(5'd16, 8'h00, "R1 pending");

    wr(5'd1, 8'hFF);
    rd(5'd2, 8'hC0, "R2 R3 release all");
    per_out = 8'hA5; per_oe = 8'h0F; pad_in = 8'h5A;
    @(negedge clk);
    chk("R7 pad_out", pad_out, 8'h25);
    chk("R7 pad_oe", pad_oe, 8'h0F);
    chk("R4 per_in periph", per_in, 8'h1A);
    wr(5'd0, 8'h0F);
    rd(5'd2, 8'hCF, "R2 reclaim");
    chk("R4 per_in mixed", per_in, 8'h10);

    wr(5'd3, 8'hF0); wr(5'd4, 8'h30);
    rd(5'd5, 8'hC0, "R5 dir status");
    wr(5'd6, 8'hFF); wr(5'd7, 8'h55);
    rd(5'd8, 8'hAA, "R6 data status");
    chk("R5 R7 pad_oe", pad_oe, 8'hC0);
    chk("R6 R7 pad_out", pad_out, 8'hAA);

    rd(5'd15, 8'h5A, "R8 pad level");
    rd(5'd16, 8'h5A, "R10 pending");
    rd(5'd16, 8'h00, "R10 cleared");

    wr(5'd12, 8'h01);
    rd(5'd14, 8'h01, "R11 ien status");
    @(negedge clk); pad_in = 8'h5B;
    edges(3); chk("R11 irq early", {7'b0, irq}, 8'h00);
    edges(1); chk("R11 irq on time", {7'b0, irq}, 8'h01);
    rd(5'd16, 8'h01, "R10 bit0 pending");
    chk("R11 irq after read", {7'b0, irq}, 8'h00);

    wr(5'd9, 8'h02);
    rd(5'd11, 8'h02, "R9 filter status");
    @(negedge clk); pad_in = 8'h5F;
    @(negedge clk); pad_in = 8'h5B;
    edges(8);
    rd(5'd16, 8'h04, "R9 unfiltered pulse kept");
    @(negedge clk); pad_in = 8'h59;
    @(negedge clk); pad_in = 8'h5B;
    edges(8);
    rd(5'd16, 8'h00, "R9 filtered pulse dropped");

    wr(5'd12, 8'h02); wr(5'd13, 8'h01);
    rd(5'd14, 8'h02, "R11 ien swap");
    @(negedge clk); pad_in = 8'h59;
    edges(4); chk("R9 filtered early", {7'b0, irq}, 8'h00);
    edges(1); chk("R9 filtered on time", {7'b0, irq}, 8'h01);
    rd(5'd16, 8'h02, "R9 filtered change");
    wr(5'd10, 8'h02);
    rd(5'd11, 8'h00, "R9 filter cleared");

    edges(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule